// File: doc/BRIEF.md
# Adder-Based Integer Compare Unit

This block compares two integer operands by subtracting them in one shared adder instead of a separate magnitude comparator. The adder forms the inverted first operand plus the second operand plus one, which is B minus A. The carry out of that sum, together with the top bits of the operands, gives the ordering. A direct XOR of the operands gives equality. A mode input selects a signed or an unsigned comparison. A size input selects a full-width comparison or one over the low half only.

The result is a four-bit condition nibble holding less-than, greater-than, equal and summary-overflow. The nibble is copied into every slot of a 32-bit condition word. A one-hot mask picks the one slot that the write should update, from a three-bit field index. The adder's raw difference is also brought out, so the same adder can feed an ordinary add path. All outputs are registered and appear one clock after an input strobe.

Top module: `adder_cmp_unit`

## Requirements
- R1: While reset is held and after it is released, before any strobe, `wr_en`, `cond_nib`, `wr_mask`, `wr_word` and `diff` are all zero.
- R2: In full-width mode (`wide`=1) the EQ bit is set exactly when all 64 bits of `op_a` equal `op_b`.
- R3: In half-width mode (`wide`=0) bits 63:32 of both operands have no effect on `cond_nib`. Only bits 31:0 are compared, and the sign bit is bit 31.
- R4: With `sgn`=1 the operands are two's complement numbers. LT is set when A < B, GT when A > B, and the MSB-differs case picks the operand with MSB 0 as the larger.
- R5: With `sgn`=0 the operands are unsigned. LT is set when A < B, GT when A > B, and the operand with MSB 1 is the larger when the MSBs differ.
- R6: `cond_nib` is {LT, GT, EQ, SO} from bit 3 down to bit 0. Exactly one of LT, GT and EQ is set. SO is the `so_in` value given with the strobe.
- R7: `wr_mask` is one-hot, and field index n sets mask bit 7-n. Field 0 therefore selects the most significant nibble of the word.
- R8: `wr_word` holds `cond_nib` in all eight 4-bit slots.
- R9: The outputs update at the first rising edge after `in_valid` is sampled high. `wr_en` is high for exactly that one cycle. The data outputs hold while no strobe arrives.
- R10: `diff` equals `op_b - op_a` modulo 2^64, taken from the same adder used for ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| op_a | input | 64 | First operand (A) |
| op_b | input | 64 | Second operand (B) |
| sgn | input | 1 | 1 = signed compare, 0 = unsigned |
| wide | input | 1 | 1 = 64-bit compare, 0 = 32-bit compare |
| field_idx | input | 3 | Condition field to write (0 = top nibble) |
| so_in | input | 1 | Summary-overflow bit copied into the nibble |
| wr_en | output | 1 | One-cycle pulse marking a fresh result |
| cond_nib | output | 4 | {LT, GT, EQ, SO} |
| wr_mask | output | 8 | One-hot field enable |
| wr_word | output | 32 | Nibble replicated into all eight slots |
| diff | output | 64 | Adder result B - A |

## Verification
Two kinds of fault matter here. A wrong carry tap, such as the half-width carry taken at the wrong bit, or an inverted MSB rule, shows up as LT and GT swapped. This happens only for operand pairs that straddle a sign boundary or differ only above bit 31. An equality fault shows as EQ set together with an ordering bit, or as EQ lost when only the upper half differs in narrow mode. Each of these faults appears in the registered outputs one cycle after the strobe that triggers it. That is why the bench sweeps every pair from a boundary value set, in both modes and both sizes.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
   localparam int NIB_W = 4;
   localparam int NIB_LT = 3;
   localparam int NIB_GT = 2;
   localparam int NIB_EQ = 1;
   localparam int NIB_SO = 0;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } cond_nib_t;
endpackage

// File: rtl/cmpu_adder.sv
module cmpu_adder #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] sum,
   output logic              carry_full,
   output logic              carry_half
);
   localparam int HALF = DATA_W / 2;

   logic [DATA_W:0]   ext_sum;
   logic [DATA_W-1:0] a_inv;

   always_comb begin
      a_inv   = ~a;
      ext_sum = {1'b0, a_inv} + {1'b0, b} + {{DATA_W{1'b0}}, 1'b1};
   end

   assign sum        = ext_sum[DATA_W-1:0];
   assign carry_full = ext_sum[DATA_W];
   // carry into the half boundary recovered from the sum bit
   assign carry_half = ext_sum[HALF] ^ a_inv[HALF] ^ b[HALF];
endmodule

// File: rtl/cmpu_order.sv
module cmpu_order #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              carry_full,
   input  logic              carry_half,
   input  logic              wide,
   input  logic              sgn,
   output logic              eq,
   output logic              lt
);
   localparam int HALF = DATA_W / 2;

   logic eq_lo, eq_hi, msb_a, msb_b, lt_raw;

   always_comb begin
      eq_lo = ~|(a[HALF-1:0] ^ b[HALF-1:0]);
      eq_hi = ~|(a[DATA_W-1:HALF] ^ b[DATA_W-1:HALF]);
      eq    = eq_lo & (~wide | eq_hi);
      msb_a = wide ? a[DATA_W-1] : a[HALF-1];
      msb_b = wide ? b[DATA_W-1] : b[HALF-1];
      if (msb_a != msb_b)
         lt_raw = ~(msb_a ^ sgn);
      else
         lt_raw = wide ? carry_full : carry_half;
      lt = lt_raw & ~eq;
   end

   always_comb begin
      // R6: equal operands never report an ordering
      a_r6_eq_excl: assert (!(eq && lt));
   end
endmodule

// File: rtl/cmpu_field.sv
module cmpu_field #(
   parameter int FIELDS      = 8,
   parameter int NIB_W       = 4,
   parameter bit ZERO_AT_TOP = 1'b1
) (
   input  logic [$clog2(FIELDS)-1:0] idx,
   input  logic [NIB_W-1:0]          nib,
   output logic [FIELDS-1:0]         mask,
   output logic [FIELDS*NIB_W-1:0]   word
);
   localparam int IDX_W = $clog2(FIELDS);

   for (genvar g = 0; g < FIELDS; g++) begin : g_slot
      localparam int FNUM = ZERO_AT_TOP ? (FIELDS - 1 - g) : g;
      assign mask[g] = (idx == IDX_W'(FNUM));
      assign word[g*NIB_W +: NIB_W] = nib;
   end
endmodule

// File: rtl/adder_cmp_unit.sv
module adder_cmp_unit #(
   parameter int DATA_W      = 64,
   parameter int FIELDS      = 8,
   parameter bit ZERO_AT_TOP = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [DATA_W-1:0]         op_a,
   input  logic [DATA_W-1:0]         op_b,
   input  logic                      sgn,
   input  logic                      wide,
   input  logic [$clog2(FIELDS)-1:0] field_idx,
   input  logic                      so_in,
   output logic                      wr_en,
   output logic [3:0]                cond_nib,
   output logic [FIELDS-1:0]         wr_mask,
   output logic [FIELDS*4-1:0]       wr_word,
   output logic [DATA_W-1:0]         diff
);
   import cmpu_pkg::*;

   localparam int WORD_W = FIELDS * NIB_W;

   initial begin
      if (DATA_W < 4 || DATA_W % 2 != 0)
         $error("DATA_W must be even and at least 4");
      if (FIELDS < 2 || (FIELDS & (FIELDS - 1)) != 0)
         $error("FIELDS must be a power of two");
   end

   logic [DATA_W-1:0] sum_c;
   logic              c_full, c_half, eq_c, lt_c;
   cond_nib_t         nib_c;
   logic [FIELDS-1:0] mask_c;
   logic [WORD_W-1:0] word_c;

   cmpu_adder #(.DATA_W(DATA_W)) u_add (
      .a(op_a), .b(op_b), .sum(sum_c),
      .carry_full(c_full), .carry_half(c_half)
   );

   cmpu_order #(.DATA_W(DATA_W)) u_ord (
      .a(op_a), .b(op_b), .carry_full(c_full), .carry_half(c_half),
      .wide(wide), .sgn(sgn), .eq(eq_c), .lt(lt_c)
   );

   always_comb begin
      nib_c.lt = lt_c;
      nib_c.gt = ~lt_c & ~eq_c;
      nib_c.eq = eq_c;
      nib_c.so = so_in;
   end

   cmpu_field #(.FIELDS(FIELDS), .NIB_W(NIB_W), .ZERO_AT_TOP(ZERO_AT_TOP)) u_fld (
      .idx(field_idx), .nib(nib_c), .mask(mask_c), .word(word_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en    <= 1'b0;
         cond_nib <= '0;
         wr_mask  <= '0;
         wr_word  <= '0;
         diff     <= '0;
      end else begin
         wr_en <= in_valid;
         if (in_valid) begin
            cond_nib <= nib_c;
            wr_mask  <= mask_c;
            wr_word  <= word_c;
            diff     <= sum_c;
         end
      end
   end

   // R9: a pulse only follows a strobe
   a_r9_pulse_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(in_valid));
   // R9: data holds without a strobe
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> $stable(cond_nib));
   // R7: one-hot mask on each result
   a_r7_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $countones(wr_mask) == 1);
   // R6: exactly one of LT/GT/EQ
   a_r6_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $countones(cond_nib[3:1]) == 1);
   // R6: SO copied from the strobe cycle
   a_r6_so_copy: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> cond_nib[0] == $past(so_in));
   // R8: lowest slot of the word matches the nibble
   a_r8_slot0: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_word[3:0] == cond_nib);
endmodule

// File: tb/adder_cmp_unit_tb.sv
module adder_cmp_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [63:0] op_a, op_b;
   logic        sgn, wide, so_in;
   logic [2:0]  field_idx;
   logic        wr_en;
   logic [3:0]  cond_nib;
   logic [7:0]  wr_mask;
   logic [31:0] wr_word;
   logic [63:0] diff;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   adder_cmp_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .sgn(sgn), .wide(wide), .field_idx(field_idx), .so_in(so_in),
      .wr_en(wr_en), .cond_nib(cond_nib), .wr_mask(wr_mask),
      .wr_word(wr_word), .diff(diff)
   );

   function automatic logic [63:0] pick(input int i);
      case (i)
         0:  return 64'h0;
         1:  return 64'h1;
         2:  return 64'h0000_0000_7FFF_FFFF;
         3:  return 64'h0000_0000_8000_0000;
         4:  return 64'h0000_0000_FFFF_FFFF;
         5:  return 64'h0000_0001_0000_0000;
         6:  return 64'h7FFF_FFFF_FFFF_FFFF;
         7:  return 64'h8000_0000_0000_0000;
         8:  return 64'hFFFF_FFFF_FFFF_FFFF;
         9:  return 64'hFFFF_FFFF_0000_0001;
         10: return 64'h1234_5678_8000_0005;
         default: return 64'hDEAD_BEEF_0000_0005;
      endcase
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_one(input logic [63:0] a, input logic [63:0] b,
                          input logic s, input logic w, input logic [2:0] f, input logic so);
      logic lt, gt, eq;
      logic [3:0] en;
      @(negedge clk);
      op_a = a; op_b = b; sgn = s; wide = w; field_idx = f; so_in = so; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      if (w) begin
         eq = (a == b);
         lt = s ? ($signed(a) < $signed(b)) : (a < b);
      end else begin
         eq = (a[31:0] == b[31:0]);
         lt = s ? ($signed(a[31:0]) < $signed(b[31:0])) : (a[31:0] < b[31:0]);
      end
      gt = !lt && !eq;
      en = {lt, gt, eq, so};
      // R2 R3 R4 R5 R6: nibble contents
      check(w ? (s ? "R2/R4" : "R2/R5") : (s ? "R3/R4" : "R3/R5"), 64'(cond_nib), 64'(en));
      check("R7", 64'(wr_mask), 64'(8'h80 >> f));
      check("R8", 64'(wr_word), 64'({8{en}}));
      check("R10", diff, b - a);
      check("R9", 64'(wr_en), 64'd1);
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
      sgn = 1'b0; wide = 1'b0; field_idx = '0; so_in = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", 64'({wr_en, cond_nib, wr_mask}), 64'd0);
      check("R1", {wr_word, 32'd0}, 64'd0);
      check("R1", diff, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 64'({wr_en, cond_nib, wr_mask}), 64'd0);

      // R3: upper halves differ, low halves equal, narrow mode -> EQ
      op_a = 64'hAAAA_0000_1234_5678; op_b = 64'h5555_FFFF_1234_5678;
      sgn = 1'b1; wide = 1'b0; so_in = 1'b1; field_idx = 3'd2; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R3", 64'(cond_nib), 64'b0011);
      // R9: pulse lasts one cycle, data holds while the inputs change
      op_a = 64'd9; op_b = 64'd1; so_in = 1'b0; field_idx = 3'd5;
      @(negedge clk);
      check("R9", 64'(wr_en), 64'd0);
      check("R9", 64'({cond_nib, wr_mask}), 64'({4'b0011, 8'h20}));

      for (int s = 0; s < 2; s++)
         for (int w = 0; w < 2; w++)
            for (int i = 0; i < 12; i++)
               for (int j = 0; j < 12; j++)
                  run_one(pick(i), pick(j), s[0], w[0], 3'((i + j + s) % 8), (i ^ j ^ w) & 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule